// File: doc/BRIEF.md
# RGMII Transmit Clock Generator

This block builds the gigabit transmit clock for an RGMII MAC inside a single fast fabric clock domain. Two reference clock inputs are synchronised and turned into rising-edge ticks. A one-bit select picks one tick stream. A programmable integer divider counts the selected ticks, a fixed toggle stage halves the result, and a gate passes the clock to the output or holds it low. A second output carries the same clock shifted by a programmable number of quarter periods. This lets the transmit clock edge be centred in the data eye at the far end.

A seven-bit configuration word is loaded through a single-cycle write strobe. Settings are picked up at safe points rather than at the write. A new divisor waits for the end of the current half period. The gate opens or closes only while the halved clock is low. So a configuration change never produces a shortened high or low phase. The phase-delay stage runs on the fast clock, which is nominally four times the output frequency. Each delay step is therefore QSTEP fast-clock cycles, one quarter of an 8 ns period at 125 MHz.

Top module: `txclk_gen`

## Requirements
- R1: While `rst` is high and after its release, `tx_clk` and `tx_clk_dly` stay low. The configuration resets to select 0, divider code 2, gate closed and delay code 0.
- R2: A write with `cfg_we` high loads `cfg_wdata` in one cycle. The fields are: bit 0 the source select, bits 3:1 the divider code, bit 4 the gate enable, bits 6:5 the delay code.
- R3: Select value 0 counts rising edges of `ref_a_clk` and value 1 counts rising edges of `ref_b_clk`. The output period is 2·N·Tref, where Tref is the period of the selected reference.
- R4: Divider codes 2 to 7 divide the selected reference by the code value, before the fixed divide-by-two.
- R5: Divider codes 0 and 1 act as divide-by-one, so the output period is 2·Tref and the clock never stalls.
- R6: The high time and the low time of `tx_clk` are each N·Tref, for odd N as well as even N.
- R7: After a divider code change, every half phase of `tx_clk` lasts exactly N·Tref for either the old or the new N, and the new N holds once the change has settled.
- R8: With the gate closed, `tx_clk` stays low. The gate changes state only while the halved clock is low, so every high pulse has the full width.
- R9: `tx_clk_dly` equals `tx_clk` delayed by code·QSTEP fast-clock cycles, for delay codes 0 to 3.
- R10: The halved clock changes only in the cycle after a tick from the selected reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, four times the target output rate |
| rst | input | 1 | Synchronous active-high reset |
| ref_a_clk | input | 1 | Reference clock selected by select value 0 |
| ref_b_clk | input | 1 | Reference clock selected by select value 1 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration word (fields in R2) |
| tx_clk | output | 1 | Gated transmit clock |
| tx_clk_dly | output | 1 | Phase-shifted copy of the transmit clock |

## Verification
The bound checker covers the relations between stages on every cycle:
- the halved clock moves only after a source tick;
- the active divisor is replaced only at a divided boundary and is never zero;
- the gate state changes only while the halved clock is low, and `tx_clk` falls only after the halved clock has fallen;
- the configuration holds between writes;
- with delay code 0 the two outputs match.

Only the directed scenarios can show the measured periods and duty for each divider code and source, the mix of half phases across a divisor change, the full pulse widths across gate opening and closing, and the exact cycle offset for each nonzero delay code.

// File: rtl/txclk_pkg.sv
package txclk_pkg;

  localparam int DIV_W = 3;
  localparam int DLY_W = 2;
  localparam int CFG_W = DLY_W + 1 + DIV_W + 1;

  // Packed order gives: [6:5] delay, [4] gate, [3:1] divider, [0] source.
  typedef struct packed {
    logic [DLY_W-1:0] dly;
    logic             gate;
    logic [DIV_W-1:0] div;
    logic             src;
  } txclk_cfg_t;

  // Codes below two collapse to divide-by-one so the counter never stalls.
  function automatic logic [DIV_W-1:0] div_factor(input logic [DIV_W-1:0] code);
    if (code < DIV_W'(2)) return DIV_W'(1);
    return code;
  endfunction

endpackage

// File: rtl/txclk_src_pick.sv
module txclk_src_pick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_a_clk,
  input  logic ref_b_clk,
  input  logic sel,
  output logic src_tick
);

  localparam int NREF = 2;

  logic [NREF-1:0] ref_in;
  logic [NREF-1:0] rise;
  logic            tick_q;

  assign ref_in = {ref_b_clk, ref_a_clk};

  // One synchroniser plus edge history per reference input.
  for (genvar g = 0; g < NREF; g++) begin : g_ref
    logic [SYNC_STAGES:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[SYNC_STAGES-1:0], ref_in[g]};
    end
    assign rise[g] = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  end

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= sel ? rise[1] : rise[0];
  end

  assign src_tick = tick_q;

endmodule

// File: rtl/txclk_div.sv
module txclk_div
  import txclk_pkg::*;
#(
  parameter logic [DIV_W-1:0] RST_DIV_CODE = DIV_W'(2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] div_code,
  output logic             half_clk,
  output logic             wrap,
  output logic [DIV_W-1:0] div_act
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] act_q;
  logic             half_q;
  logic             wrap_q;
  logic             wrap_c;

  assign wrap_c = src_tick && (cnt_q == act_q - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      act_q  <= div_factor(RST_DIV_CODE);
      half_q <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= wrap_c;
      if (src_tick) begin
        if (wrap_c) begin
          cnt_q  <= '0;
          half_q <= ~half_q;
          // The new divisor is picked up only at a half-period boundary.
          act_q  <= div_factor(div_code);
        end else begin
          cnt_q <= cnt_q + DIV_W'(1);
        end
      end
    end
  end

  assign half_clk = half_q;
  assign wrap     = wrap_q;
  assign div_act  = act_q;

endmodule

// File: rtl/txclk_gate_phase.sv
module txclk_gate_phase
  import txclk_pkg::*;
#(
  parameter int QSTEP = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             half_clk,
  input  logic             gate_en,
  input  logic [DLY_W-1:0] dly_code,
  output logic             gate_on,
  output logic             tx_clk,
  output logic             tx_clk_dly
);

  localparam int TAPS  = ((1 << DLY_W) - 1) * QSTEP + 1;
  localparam int IDX_W = $clog2(TAPS + 1);

  logic            gate_q;
  logic            tx_next;
  logic            tx_q;
  logic            dly_q;
  logic [TAPS-2:0] hist_q;
  logic [TAPS-1:0] taps;
  logic [IDX_W-1:0] idx;

  // The gate follows its enable only while the halved clock is low.
  always_ff @(posedge clk) begin
    if (rst)            gate_q <= 1'b0;
    else if (!half_clk) gate_q <= gate_en;
  end

  assign tx_next = half_clk & gate_q;
  assign taps    = {hist_q, tx_next};
  assign idx     = IDX_W'(dly_code) * IDX_W'(QSTEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= 1'b0;
      dly_q  <= 1'b0;
      hist_q <= '0;
    end else begin
      tx_q   <= tx_next;
      hist_q <= taps[TAPS-2:0];
      dly_q  <= taps[idx];
    end
  end

  assign gate_on    = gate_q;
  assign tx_clk     = tx_q;
  assign tx_clk_dly = dly_q;

endmodule

// File: rtl/txclk_gen.sv
module txclk_gen
  import txclk_pkg::*;
#(
  parameter int               SYNC_STAGES  = 2,
  parameter int               QSTEP        = 1,
  parameter logic [DIV_W-1:0] RST_DIV_CODE = DIV_W'(2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_a_clk,
  input  logic             ref_b_clk,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             tx_clk,
  output logic             tx_clk_dly
);

  txclk_cfg_t       cfg_q;
  logic             src_tick;
  logic             half_clk;
  logic             wrap;
  logic [DIV_W-1:0] div_act;
  logic             gate_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '0;
      cfg_q.div  <= RST_DIV_CODE;
    end else if (cfg_we) begin
      cfg_q <= txclk_cfg_t'(cfg_wdata);
    end
  end

  txclk_src_pick #(.SYNC_STAGES(SYNC_STAGES)) src_i (
    .clk(clk), .rst(rst), .ref_a_clk(ref_a_clk), .ref_b_clk(ref_b_clk),
    .sel(cfg_q.src), .src_tick(src_tick)
  );

  txclk_div #(.RST_DIV_CODE(RST_DIV_CODE)) div_i (
    .clk(clk), .rst(rst), .src_tick(src_tick), .div_code(cfg_q.div),
    .half_clk(half_clk), .wrap(wrap), .div_act(div_act)
  );

  txclk_gate_phase #(.QSTEP(QSTEP)) gate_i (
    .clk(clk), .rst(rst), .half_clk(half_clk), .gate_en(cfg_q.gate),
    .dly_code(cfg_q.dly), .gate_on(gate_on), .tx_clk(tx_clk),
    .tx_clk_dly(tx_clk_dly)
  );

endmodule

// File: rtl/txclk_gen_chk.sv
module txclk_gen_chk
  import txclk_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg,
  input logic             src_tick,
  input logic             half_clk,
  input logic             wrap,
  input logic [DIV_W-1:0] div_act,
  input logic             gate_on,
  input logic             tx_clk,
  input logic             tx_clk_dly
);

  logic [DLY_W-1:0] dly_f;
  assign dly_f = cfg[CFG_W-1 -: DLY_W];

  a_r10_half_after_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(half_clk) |-> $past(src_tick));

  a_r7_div_at_boundary: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_act) |-> wrap);

  a_r5_div_nonzero: assert property (@(posedge clk) disable iff (rst)
    div_act != '0);

  a_r8_gate_while_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(gate_on) |-> !$past(half_clk));

  a_r8_full_pulse: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_clk) |-> !$past(half_clk));

  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_we) |-> $stable(cfg));

  a_r9_zero_delay: assert property (@(posedge clk) disable iff (rst)
    ($past(dly_f) == '0) |-> (tx_clk_dly == tx_clk));

endmodule

bind txclk_gen txclk_gen_chk chk_i (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg(cfg_q), .src_tick(src_tick),
  .half_clk(half_clk), .wrap(wrap), .div_act(div_act), .gate_on(gate_on),
  .tx_clk(tx_clk), .tx_clk_dly(tx_clk_dly)
);

// File: tb/txclk_gen_tb_top.sv
`timescale 1ns/1ps
module txclk_gen_tb_top;

  localparam int TA = 4;
  localparam int TB = 6;
  localparam int QS = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_a = 1'b0;
  logic       ref_b = 1'b0;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic       tx_clk;
  logic       tx_clk_dly;

  int n_chk  = 0;
  int n_fail = 0;
  int ca = 0;
  int cb = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  txclk_gen #(.QSTEP(QS)) dut_i (
    .clk(clk), .rst(rst), .ref_a_clk(ref_a), .ref_b_clk(ref_b),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .tx_clk(tx_clk),
    .tx_clk_dly(tx_clk_dly)
  );

  always @(negedge clk) begin
    ca = (ca + 1) % TA;
    cb = (cb + 1) % TB;
    ref_a <= (ca < TA / 2);
    ref_b <= (cb < TB / 2);
  end

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_pair(input string req, input int got, input int e0, input int e1);
    n_chk++;
    if (got != e0 && got != e1) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d or %0d", req, got, e0, e1);
    end
  endtask

  // R2 layout: [6:5] delay, [4] gate, [3:1] divider code, [0] source.
  task automatic write_cfg(input int dly, input bit gate, input int div, input bit src);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = {dly[1:0], gate, div[2:0], src};
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic wait_lvl(input logic v);
    int n = 0;
    while (tx_clk !== v && n < 4000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure(output int hi, output int lo);
    wait_lvl(1'b0);
    wait_lvl(1'b1);
    hi = 0;
    while (tx_clk === 1'b1 && hi < 4000) begin hi++; @(negedge clk); end
    lo = 0;
    while (tx_clk === 1'b0 && lo < 4000) begin lo++; @(negedge clk); end
  endtask

  task automatic t_reset();
    int highs = 0;
    check("R1 tx_clk in reset", int'(tx_clk), 0);
    check("R1 tx_clk_dly in reset", int'(tx_clk_dly), 0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (tx_clk === 1'b1 || tx_clk_dly === 1'b1) highs++;
    end
    check("R1 R8 outputs low with reset gate closed", highs, 0);
  endtask

  task automatic t_div(input string req, input int code, input bit src, input int tref);
    int hi, lo, n;
    n = (code < 2) ? 1 : code;
    write_cfg(0, 1'b1, code, src);
    measure(hi, lo);
    measure(hi, lo);
    measure(hi, lo);
    check({req, " high time"}, hi, n * tref);
    check({req, " low time"}, lo, n * tref);
  endtask

  task automatic t_switch();
    int hi, lo;
    write_cfg(0, 1'b1, 3, 1'b0);
    measure(hi, lo);
    measure(hi, lo);
    wait_lvl(1'b1);
    repeat (5) @(negedge clk);
    write_cfg(0, 1'b1, 5, 1'b0);
    for (int k = 0; k < 3; k++) begin
      measure(hi, lo);
      check_pair("R7 high phase during change", hi, 3 * TA, 5 * TA);
      check_pair("R7 low phase during change", lo, 3 * TA, 5 * TA);
    end
    measure(hi, lo);
    check("R7 settled high", hi, 5 * TA);
    check("R7 settled low", lo, 5 * TA);
  endtask

  task automatic t_gate();
    int run = 0;
    int bad = 0;
    int pulses = 0;
    int late = 0;
    write_cfg(0, 1'b0, 3, 1'b0);
    repeat (40) @(negedge clk);
    write_cfg(0, 1'b1, 3, 1'b0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (i == 97) begin
        cfg_we = 1'b1;
        cfg_wdata = {2'd0, 1'b0, 3'd3, 1'b0};
      end else begin
        cfg_we = 1'b0;
      end
      if (tx_clk === 1'b1) run++;
      else begin
        if (run != 0) begin
          pulses++;
          if (run != 3 * TA) bad++;
        end
        run = 0;
      end
    end
    check("R8 pulses with wrong width around gate changes", bad, 0);
    check("R8 gate opened produced pulses", int'(pulses > 0), 1);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (tx_clk !== 1'b0) late++;
    end
    check("R8 output low after gate closed", late, 0);
  endtask

  task automatic t_delay(input int code);
    logic hist [0:15];
    int miss = 0;
    for (int i = 0; i < 16; i++) hist[i] = 1'b0;
    write_cfg(code, 1'b1, 2, 1'b0);
    for (int i = 0; i < 140; i++) begin
      @(negedge clk);
      for (int j = 15; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = tx_clk;
      if (i >= 20 && tx_clk_dly !== hist[code * QS]) miss++;
    end
    check($sformatf("R9 delay code %0d mismatched cycles", code), miss, 0);
  endtask

  initial begin
    repeat (6) @(negedge clk);
    t_reset();
    t_div("R4 code 2 src a", 2, 1'b0, TA);
    t_div("R4 code 7 src a", 7, 1'b0, TA);
    t_div("R3 R2 code 3 src b", 3, 1'b1, TB);
    t_div("R5 code 0 bypass", 0, 1'b0, TA);
    t_div("R5 code 1 bypass", 1, 1'b1, TB);
    t_div("R6 odd code 5 duty", 5, 1'b1, TB);
    t_switch();
    t_gate();
    for (int d = 0; d < 4; d++) t_delay(d);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule